// File: doc/BRIEF.md
# Confirmed Command/Indicate Change Detector

This block watches the command/indicate (C/I) field of a time-division serial bus. An upstream deframer extracts the field and presents it once per frame together with a one-cycle strobe. A new value is passed on only after the filter has confirmed it. In normal mode the filter is a double last-look filter: a value that differs from the last accepted one must arrive in two frames in a row before it counts. When the bypass pin is high, any change counts in the frame where it first appears.

An accepted value is loaded into a one-entry output register and shown on a valid/ready stream port. The host takes the value by raising `out_ready` while `out_valid` is high. The upstream bus cannot be stalled, so back-pressure never blocks the filter. If a new value is accepted while the old one is still unread, the new value overwrites it and `overrun` is set. If the accept and the handshake happen in the same cycle, the new value replaces the consumed one and no overrun is flagged.

Each accept also sets an interrupt event latch. The latch is shown on `irq` unless `irq_mask` is high. The latch stays set until the host pulses `irq_clr`.

Top module: `ci_change_det`

## Requirements
- R1: After reset, `out_valid`, `overrun` and `irq` are 0, and `out_data` is all zeros.
- R2: In normal mode (`bypass`=0), a value that differs from the last accepted value is accepted only when it is strobed in two consecutive frames. A single frame of a new value changes no output.
- R3: A strobed value equal to the last accepted value is never accepted. Cycles with `frame_stb`=0 have no effect on the filter.
- R4: If a pending candidate is followed by a different value, the new value becomes the candidate. If it is followed by the last accepted value, the candidate is dropped.
- R5: With `bypass`=1, a strobed value that differs from the last accepted value is accepted in that same frame.
- R6: The last accepted value resets to all ones, so all-ones frames right after reset are never accepted.
- R7: On accept, `out_data` takes the value and `out_valid` goes to 1 on the next cycle. A handshake (`out_valid` and `out_ready`) with no accept clears `out_valid`. An accept during a handshake leaves `out_valid` at 1 with the new data.
- R8: An accept while `out_valid`=1 and `out_ready`=0 sets `overrun`. `overrun` is cleared by a handshake and is only ever 1 while `out_valid` is 1.
- R9: An accept sets the interrupt event. `irq_clr` clears it, and an accept in the same cycle wins. `irq` equals the event AND NOT `irq_mask`, with no delay from `irq_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle strobe marking a new frame's C/I value |
| ci_in | input | CI_W | C/I field of the current frame |
| bypass | input | 1 | 1 = accept changes at once, 0 = double last-look filter |
| out_ready | input | 1 | Host takes the buffered value |
| irq_mask | input | 1 | 1 = hold `irq` low |
| irq_clr | input | 1 | Pulse that clears the interrupt event |
| out_data | output | CI_W | Last accepted C/I value |
| out_valid | output | 1 | Buffered value is unread |
| overrun | output | 1 | An unread value was overwritten |
| irq | output | 1 | Level interrupt request |

## Verification
The data, valid and overrun outputs are registered. They reflect a strobe or handshake one clock after the edge that samples it. `irq` follows its event latch with the same one-cycle delay, but it responds to `irq_mask` in the same cycle. The bench drives all inputs on the falling edge. It samples one nanosecond after that edge, when the previous rising edge has settled every register and the new mask value has already propagated. At that point it compares each output with a behavioural model that was advanced on the same rising edge.

// File: rtl/ci_pkg.sv
package ci_pkg;
  parameter int CI_W_DEF = 4;

  typedef enum logic {
    FLT_IDLE  = 1'b0,
    FLT_ARMED = 1'b1
  } flt_state_e;
endpackage

// File: rtl/ci_lastlook.sv
module ci_lastlook #(
  parameter int CI_W = ci_pkg::CI_W_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stb_i,
  input  logic [CI_W-1:0] val_i,
  input  logic            bypass_i,
  output logic            acc_o,
  output logic [CI_W-1:0] last_o
);
  import ci_pkg::*;

  localparam logic [CI_W-1:0] LAST_RST = {CI_W{1'b1}};

  flt_state_e      st_q, st_d;
  logic [CI_W-1:0] cand_q, cand_d;
  logic [CI_W-1:0] last_q, last_d;
  logic            differs, matches_cand, acc;

  assign differs      = (val_i != last_q);
  assign matches_cand = (st_q == FLT_ARMED) && (val_i == cand_q);

  always_comb begin
    st_d   = st_q;
    cand_d = cand_q;
    last_d = last_q;
    acc    = 1'b0;
    if (stb_i) begin
      if (bypass_i) begin
        st_d = FLT_IDLE;
        acc  = differs;
      end else if (!differs) begin
        st_d = FLT_IDLE;
      end else if (matches_cand) begin
        st_d = FLT_IDLE;
        acc  = 1'b1;
      end else begin
        st_d   = FLT_ARMED;
        cand_d = val_i;
      end
      if (acc) last_d = val_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FLT_IDLE;
      cand_q <= '0;
      last_q <= LAST_RST;
    end else begin
      st_q   <= st_d;
      cand_q <= cand_d;
      last_q <= last_d;
    end
  end

  assign acc_o  = acc;
  assign last_o = last_q;
endmodule

// File: rtl/ci_outbuf.sv
module ci_outbuf #(
  parameter int CI_W = ci_pkg::CI_W_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_i,
  input  logic [CI_W-1:0] val_i,
  input  logic            ready_i,
  output logic [CI_W-1:0] data_o,
  output logic            valid_o,
  output logic            ovr_o
);
  logic [CI_W-1:0] data_q;
  logic            full_q, ovr_q, take;

  assign take = full_q && ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (acc_i) begin
      data_q <= val_i;
      full_q <= 1'b1;
      ovr_q  <= full_q && !ready_i;
    end else if (take) begin
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end
  end

  assign data_o  = data_q;
  assign valid_o = full_q;
  assign ovr_o   = ovr_q;
endmodule

// File: rtl/ci_irqgen.sv
module ci_irqgen (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_i,
  input  logic clr_i,
  input  logic mask_i,
  output logic irq_o
);
  logic evt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      evt_q <= 1'b0;
    else if (acc_i)  evt_q <= 1'b1;
    else if (clr_i)  evt_q <= 1'b0;
  end

  assign irq_o = evt_q && !mask_i;
endmodule

// File: rtl/ci_change_det.sv
module ci_change_det #(
  parameter int CI_W = ci_pkg::CI_W_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_stb,
  input  logic [CI_W-1:0] ci_in,
  input  logic            bypass,
  input  logic            out_ready,
  input  logic            irq_mask,
  input  logic            irq_clr,
  output logic [CI_W-1:0] out_data,
  output logic            out_valid,
  output logic            overrun,
  output logic            irq
);
  logic            acc_stb;
  logic [CI_W-1:0] last_val;

  ci_lastlook #(.CI_W(CI_W)) u_flt (
    .clk(clk), .rst_n(rst_n), .stb_i(frame_stb), .val_i(ci_in),
    .bypass_i(bypass), .acc_o(acc_stb), .last_o(last_val)
  );

  ci_outbuf #(.CI_W(CI_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .acc_i(acc_stb), .val_i(ci_in),
    .ready_i(out_ready), .data_o(out_data), .valid_o(out_valid),
    .ovr_o(overrun)
  );

  ci_irqgen u_irq (
    .clk(clk), .rst_n(rst_n), .acc_i(acc_stb), .clr_i(irq_clr),
    .mask_i(irq_mask), .irq_o(irq)
  );
endmodule

// File: rtl/ci_change_chk.sv
module ci_change_chk #(
  parameter int CI_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            frame_stb,
  input logic [CI_W-1:0] ci_in,
  input logic            bypass,
  input logic            out_ready,
  input logic            irq_mask,
  input logic [CI_W-1:0] out_data,
  input logic            out_valid,
  input logic            overrun,
  input logic            irq,
  input logic            acc_stb,
  input logic [CI_W-1:0] last_val
);
  AST_BYPASS_TAKES_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb && bypass && (ci_in != last_val) |=> out_valid && (out_data == $past(ci_in))); // R5

  AST_SAME_VALUE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb && (ci_in == last_val) |=> $stable(out_data)); // R3

  AST_VALID_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(frame_stb)); // R2

  AST_HANDSHAKE_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !acc_stb |=> !out_valid && !overrun); // R7

  AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> out_valid); // R8

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |-> !irq); // R9
endmodule

bind ci_change_det ci_change_chk #(.CI_W(CI_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .ci_in(ci_in),
  .bypass(bypass), .out_ready(out_ready), .irq_mask(irq_mask),
  .out_data(out_data), .out_valid(out_valid), .overrun(overrun), .irq(irq),
  .acc_stb(acc_stb), .last_val(last_val)
);

// File: tb/tb_ci_change_det.sv
`timescale 1ns/1ps
module tb_ci_change_det;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         frame_stb = 1'b0;
  logic [W-1:0] ci_in = '0;
  logic         bypass = 1'b0;
  logic         out_ready = 1'b0;
  logic         irq_mask = 1'b0;
  logic         irq_clr = 1'b0;
  logic [W-1:0] out_data;
  logic         out_valid, overrun, irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ci_change_det #(.CI_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .ci_in(ci_in),
    .bypass(bypass), .out_ready(out_ready), .irq_mask(irq_mask),
    .irq_clr(irq_clr), .out_data(out_data), .out_valid(out_valid),
    .overrun(overrun), .irq(irq)
  );

  // behavioural reference
  int m_last = (1 << W) - 1;
  int m_cand = 0;
  bit m_armed = 0;
  int m_data = 0;
  bit m_full = 0, m_ovr = 0, m_evt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_last = (1 << W) - 1; m_cand = 0; m_armed = 0;
      m_data = 0; m_full = 0; m_ovr = 0; m_evt = 0;
    end else begin
      bit acc;
      acc = 0;
      if (frame_stb) begin
        if (bypass) begin
          m_armed = 0;
          acc = (int'(ci_in) != m_last);
        end else if (int'(ci_in) == m_last) begin
          m_armed = 0;
        end else if (m_armed && int'(ci_in) == m_cand) begin
          m_armed = 0;
          acc = 1;
        end else begin
          m_armed = 1;
          m_cand = int'(ci_in);
        end
      end
      if (acc) begin
        m_ovr = m_full && !out_ready;
        m_full = 1;
        m_data = int'(ci_in);
        m_last = int'(ci_in);
        m_evt = 1;
      end else begin
        if (m_full && out_ready) begin m_full = 0; m_ovr = 0; end
        if (irq_clr) m_evt = 0;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      #1;
      check(int'(out_data) == m_data, "R2 data vs model", int'(out_data), m_data);
      check(out_valid == m_full, "R7 valid vs model", out_valid, m_full);
      check(overrun == m_ovr, "R8 overrun vs model", overrun, m_ovr);
      check(irq == (m_evt && !irq_mask), "R9 irq vs model", irq, m_evt && !irq_mask);
    end
  end

  task automatic frame(input int v);
    @(negedge clk); frame_stb = 1'b1; ci_in = W'(v);
    @(negedge clk); frame_stb = 1'b0;
    #1;
  endtask

  task automatic pulse_ready();
    @(negedge clk); out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;
    #1;
  endtask

  task automatic pulse_clr();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    #1;
  endtask

  task automatic expect_out(input string tag, input bit v, input int d, input bit o, input bit q);
    check(out_valid == v, {tag, " valid"}, out_valid, v);
    if (v) check(int'(out_data) == d, {tag, " data"}, int'(out_data), d);
    check(overrun == o, {tag, " overrun"}, overrun, o);
    check(irq == q, {tag, " irq"}, irq, q);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid == 0 && overrun == 0 && irq == 0 && out_data == '0,
          "R1 reset state", {out_valid, overrun, irq}, 0);

    frame(15); frame(15);
    expect_out("R6 all-ones after reset", 0, 0, 0, 0);

    frame(5);
    expect_out("R2 single frame", 0, 0, 0, 0);
    frame(5);
    expect_out("R2 confirmed", 1, 5, 0, 1);

    pulse_ready();
    expect_out("R7 drained", 0, 0, 0, 1);
    pulse_clr();
    expect_out("R9 cleared", 0, 0, 0, 0);

    frame(5); frame(5);
    expect_out("R3 repeat of accepted", 0, 0, 0, 0);

    frame(3); frame(6);
    expect_out("R4 replaced candidate", 0, 0, 0, 0);
    frame(6);
    expect_out("R4 new candidate confirmed", 1, 6, 0, 1);
    pulse_ready(); pulse_clr();

    frame(9); frame(6); frame(9);
    expect_out("R4 candidate dropped", 0, 0, 0, 0);
    frame(9);
    expect_out("R4 after drop", 1, 9, 0, 1);

    frame(2); frame(2);
    expect_out("R8 overwrite", 1, 2, 1, 1);
    pulse_ready();
    expect_out("R8 cleared", 0, 0, 0, 1);

    @(negedge clk); irq_mask = 1'b1; #1;
    check(irq == 0, "R9 masked immediately", irq, 0);
    pulse_clr();
    frame(4); frame(4);
    expect_out("R9 masked capture", 1, 4, 0, 0);
    @(negedge clk); irq_mask = 1'b0; #1;
    check(irq == 1, "R9 unmask shows event", irq, 1);
    pulse_ready(); pulse_clr();

    @(negedge clk); bypass = 1'b1;
    frame(7);
    expect_out("R5 bypass same frame", 1, 7, 0, 1);
    @(negedge clk); frame_stb = 1'b1; ci_in = 4'd1; out_ready = 1'b1;
    @(negedge clk); frame_stb = 1'b0; out_ready = 1'b0; #1;
    expect_out("R7 accept with handshake", 1, 1, 0, 1);
    @(negedge clk); bypass = 1'b0;
    pulse_ready(); pulse_clr();

    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      frame_stb = ($urandom % 3) == 0;
      ci_in     = W'($urandom % 4);
      bypass    = ($urandom % 8) == 0;
      out_ready = ($urandom % 4) == 0;
      irq_clr   = ($urandom % 5) == 0;
      irq_mask  = ($urandom % 6) == 0;
    end
    @(negedge clk);
    frame_stb = 0; out_ready = 0; irq_clr = 0; irq_mask = 0; bypass = 0;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule